// File: doc/BRIEF.md
# Infrared Remote Frame Transmitter

This block turns a 16-bit address and an 8-bit command into one pulse-distance coded remote-control frame on a single baseband line. The line has the polarity that a demodulating receiver would present. It rests high, and every burst is driven low. Carrier modulation at the emitter is left to logic further along the path.

A one-cycle `start` strobe launches the frame. The block then sends these parts in order:
- a long leader,
- 32 data bits, where each bit is a fixed low burst followed by a high gap whose length carries the bit value,
- a final low burst.

The 32 data bits are the address, then the command, then the bitwise complement of the command. Each field goes out least significant bit first. `busy` covers the whole frame, and `done` marks the cycle on which the line goes back to rest.

Every segment length is a whole number of clock cycles. Each one is derived from a clock-frequency parameter, so the same code serves a 50 MHz system clock or a scaled-down clock in simulation.

Top module: `ir_frame_tx`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to rest: `tx_n` goes high, and `busy` and `done` go low. This holds even in the middle of a frame.
- R2: The clock edge that accepts `start` begins the frame. From the next cycle, `tx_n` is low for exactly the 9 ms count, then high for exactly the 4.5 ms count.
- R3: Each data bit is a low burst of the 560 us count, followed by a high gap. The gap is the 560 us count for a 0 and the 1690 us count for a 1.
- R4: The 32 data bits are sent in this order: `addr[0]` to `addr[15]`, then `cmd[0]` to `cmd[7]`, then the inverse of `cmd[0]` to the inverse of `cmd[7]`.
- R5: After the gap of the 32nd bit, `tx_n` is low for one more 560 us count and then returns high.
- R6: `busy` is high from the cycle after the accepting edge up to the last cycle of the closing burst. `done` is high for exactly one cycle: the first cycle on which `tx_n` is high again after the closing burst. In that same cycle `busy` is low.
- R7: Two kinds of input are ignored while `busy` is high. A `start` pulse causes no restart. A change on `addr` or `cmd` does not alter the frame in progress, because both are captured when `start` is accepted.
- R8: Each segment length in cycles is `CLK_HZ * microseconds / 1000000`, truncated. With `CLK_HZ` = 50000 the counts are:
  - 450 for the 9 ms leader low,
  - 225 for the 4.5 ms leader high,
  - 28 for the 560 us burst and the 0 gap,
  - 84 for the 1690 us gap of a 1.
- R9: A `start` given during the `done` cycle is accepted, so a new frame's leader begins on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Frame launch strobe, accepted only while idle |
| addr | input | 16 | Address field, captured on accepted start |
| cmd | input | 8 | Command field, captured on accepted start |
| tx_n | output | 1 | Baseband line, high at rest, low during bursts |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle pulse when the line returns to rest |

## Verification
The scoreboard turns each frame into a list of expected low and high run lengths. It then compares every measured run of `tx_n` against that list.

The test frames are chosen so that specific faults show up:
- All-zero and all-one fields separate the two gap lengths and expose a swapped gap.
- Address 0x0001 with command 0x80 places a lone one at each end of its field, which catches bit-order and field-order faults.
- A mixed pattern catches a wrong complement.

Further stimulus covers the control behaviour:
- Start pulses and input changes are injected mid-frame to show that the captured fields are held.
- A start issued in the `done` cycle checks back-to-back launch.
- A reset in the middle of a frame checks the return to rest.

// File: rtl/ir_tx_pkg.sv
// Package: shared types and timing helper for the infrared frame transmitter.
// Assumes durations are given in whole microseconds and the clock in Hz.
package ir_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_LEAD_LO = 3'd1,
        ST_LEAD_HI = 3'd2,
        ST_BURST   = 3'd3,
        ST_GAP     = 3'd4,
        ST_STOP    = 3'd5
    } tx_state_t;

    // Converts a duration in microseconds into clock cycles, truncating.
    function automatic longint unsigned us_to_cycles(longint unsigned clk_hz,
                                                     longint unsigned usec);
        return (clk_hz * usec) / 64'd1000000;
    endfunction

    // True for the states that drive the line low.
    function automatic logic is_low_state(tx_state_t s);
        return (s == ST_LEAD_LO) || (s == ST_BURST) || (s == ST_STOP);
    endfunction

endpackage

// File: rtl/ir_tx_seg_timer.sv
// Segment timer: a down-counter loaded with (length - 1) at the start of each
// line segment; expire is high in the last cycle of the segment.
// Assumes the controller loads it on every state change and MAX_VAL bounds loads.
module ir_tx_seg_timer #(
    parameter int unsigned CNT_W   = 19,
    parameter int unsigned MAX_VAL = 449999
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expire
);

    logic [CNT_W-1:0] cnt;

    // Loads a new segment length or counts down toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expire = (cnt == '0);

    // R8
    seg_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(MAX_VAL));

endmodule

// File: rtl/ir_tx_bit_word.sv
// Frame word holder: captures {~cmd, cmd, addr} on an accepted start and
// presents the bit selected by a running index, LSB of address first.
// Assumes advance is raised once per finished data bit.
module ir_tx_bit_word #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned CMD_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic              advance,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CMD_W-1:0]  cmd,
    output logic              cur_bit,
    output logic              last
);

    localparam int unsigned WORD_W = ADDR_W + 2 * CMD_W;
    localparam int unsigned IDX_W  = $clog2(WORD_W);

    logic [WORD_W-1:0] word;
    logic [IDX_W-1:0]  idx;

    // Holds the captured frame word for the whole frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word <= '0;
        end else if (capture) begin
            word <= {~cmd, cmd, addr};
        end
    end

    // Steps the bit index from the first address bit to the last inverted bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (capture) begin
            idx <= '0;
        end else if (advance) begin
            idx <= idx + 1'b1;
        end
    end

    assign cur_bit = word[idx];
    assign last    = (idx == IDX_W'(WORD_W - 1));

    // R4
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        advance |-> !last);

endmodule

// File: rtl/ir_frame_tx.sv
// Infrared frame transmitter top: sequences leader, 32 pulse-distance bits
// and a closing burst onto an active-low baseband line.
// Assumes start is synchronous to clk; segment lengths derive from CLK_HZ.
module ir_frame_tx
    import ir_tx_pkg::*;
#(
    parameter longint unsigned CLK_HZ = 50_000_000,
    parameter int unsigned     ADDR_W = 16,
    parameter int unsigned     CMD_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CMD_W-1:0]  cmd,
    output logic              tx_n,
    output logic              busy,
    output logic              done
);

    localparam int unsigned N_LEAD_LO = 32'(us_to_cycles(CLK_HZ, 64'd9000));
    localparam int unsigned N_LEAD_HI = 32'(us_to_cycles(CLK_HZ, 64'd4500));
    localparam int unsigned N_BURST   = 32'(us_to_cycles(CLK_HZ, 64'd560));
    localparam int unsigned N_ONE     = 32'(us_to_cycles(CLK_HZ, 64'd1690));
    localparam int unsigned CNT_W     = $clog2(N_LEAD_LO + 1);

    localparam logic [CNT_W-1:0] L_LEAD_LO = CNT_W'(N_LEAD_LO - 1);
    localparam logic [CNT_W-1:0] L_LEAD_HI = CNT_W'(N_LEAD_HI - 1);
    localparam logic [CNT_W-1:0] L_BURST   = CNT_W'(N_BURST - 1);
    localparam logic [CNT_W-1:0] L_ONE     = CNT_W'(N_ONE - 1);

    tx_state_t        state, nxt;
    logic             load, capture, advance;
    logic [CNT_W-1:0] load_val;
    logic             seg_end, cur_bit, last;
    logic             tx_n_q, busy_q, done_q;

    ir_tx_seg_timer #(
        .CNT_W   (CNT_W),
        .MAX_VAL (N_LEAD_LO - 1)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .expire   (seg_end)
    );

    ir_tx_bit_word #(
        .ADDR_W (ADDR_W),
        .CMD_W  (CMD_W)
    ) u_word (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .advance (advance),
        .addr    (addr),
        .cmd     (cmd),
        .cur_bit (cur_bit),
        .last    (last)
    );

    // Chooses the next segment and the timer load that starts it.
    always_comb begin
        nxt      = state;
        load     = 1'b0;
        load_val = L_BURST;
        capture  = 1'b0;
        advance  = 1'b0;
        case (state)
            ST_IDLE: if (start) begin
                nxt      = ST_LEAD_LO;
                load     = 1'b1;
                load_val = L_LEAD_LO;
                capture  = 1'b1;
            end
            ST_LEAD_LO: if (seg_end) begin
                nxt      = ST_LEAD_HI;
                load     = 1'b1;
                load_val = L_LEAD_HI;
            end
            ST_LEAD_HI: if (seg_end) begin
                nxt  = ST_BURST;
                load = 1'b1;
            end
            ST_BURST: if (seg_end) begin
                nxt      = ST_GAP;
                load     = 1'b1;
                load_val = cur_bit ? L_ONE : L_BURST;
            end
            ST_GAP: if (seg_end) begin
                nxt     = last ? ST_STOP : ST_BURST;
                load    = 1'b1;
                advance = !last;
            end
            ST_STOP: if (seg_end) begin
                nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // Registers the state and the outputs decoded from the next state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            tx_n_q <= 1'b1;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            state  <= nxt;
            tx_n_q <= !is_low_state(nxt);
            busy_q <= (nxt != ST_IDLE);
            done_q <= (state == ST_STOP) && (nxt == ST_IDLE);
        end
    end

    assign tx_n = tx_n_q;
    assign busy = busy_q;
    assign done = done_q;

    // R1
    idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> tx_n);

    // R2
    lead_starts_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !tx_n);

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($fell(busy) && tx_n));

    // R5
    stop_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOP && seg_end) |=> done);

endmodule

// File: tb/ir_frame_tx_test.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues expected line runs for every frame,
// the monitor measures runs of tx_n and compares them in order.
module ir_frame_tx_test;

    localparam longint unsigned CLK_HZ = 50_000;
    localparam int T_LL  = int'((CLK_HZ * 9000) / 1000000);
    localparam int T_LH  = int'((CLK_HZ * 4500) / 1000000);
    localparam int T_B   = int'((CLK_HZ * 560) / 1000000);
    localparam int T_ONE = int'((CLK_HZ * 1690) / 1000000);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  cmd = '0;
    logic        tx_n, busy, done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    int    exp_lvl[$];
    int    exp_len[$];
    string exp_tag[$];

    ir_frame_tx #(.CLK_HZ(CLK_HZ)) uut (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .addr  (addr),
        .cmd   (cmd),
        .tx_n  (tx_n),
        .busy  (busy),
        .done  (done)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
        end
    endtask

    task automatic push(input int lvl, input int len, input string tag);
        exp_lvl.push_back(lvl);
        exp_len.push_back(len);
        exp_tag.push_back(tag);
    endtask

    // Expands one frame into expected runs; level 2 marks the frame end.
    task automatic push_frame(input logic [15:0] a, input logic [7:0] c);
        logic [31:0] w;
        w = {~c, c, a};
        push(0, T_LL, "R2");
        push(1, T_LH, "R2");
        for (int i = 0; i < 32; i++) begin
            push(0, T_B, "R3");
            push(1, w[i] ? T_ONE : T_B, "R4");   // gap length per R3, order per R4
        end
        push(0, T_B, "R5");
        push(2, 0, "R6");
    endtask

    // Monitor: measures each run of tx_n and checks done timing.
    int lvl_prev = 1;
    int run = 0;
    bit in_frame = 0;
    bit done_prev = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            lvl_prev = 1; run = 0; in_frame = 0; done_prev = 0;
        end else begin
            if (int'(tx_n) == lvl_prev) begin
                run++;
            end else begin
                if (!in_frame) begin
                    in_frame = 1;
                end else if (exp_lvl.size() == 0) begin
                    chk(0, "R2", "unexpected run", run, 0);
                end else begin
                    int el, en;
                    string et;
                    el = exp_lvl.pop_front();
                    en = exp_len.pop_front();
                    et = exp_tag.pop_front();
                    chk(el == lvl_prev, et, "run level", lvl_prev, el);
                    chk(en == run, et, "run length", run, en);
                    if (exp_lvl.size() != 0 && exp_lvl[0] == 2) begin
                        void'(exp_lvl.pop_front());
                        void'(exp_len.pop_front());
                        void'(exp_tag.pop_front());
                        in_frame = 0;
                        chk(done == 1'b1, "R6", "done on return to idle", done, 1);
                        chk(busy == 1'b0, "R6", "busy low on done", busy, 0);
                    end
                end
                lvl_prev = int'(tx_n);
                run = 1;
            end
            if (done_prev)
                chk(done == 1'b0, "R6", "done one cycle wide", done, 0);
            done_prev = done;
        end
    end

    // Driver: launches a frame at a negedge once the block is idle.
    task automatic send_frame(input logic [15:0] a, input logic [7:0] c,
                              input bit disturb, input string tag);
        while (busy) @(negedge clk);
        push_frame(a, c);
        addr = a; cmd = c; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, tag, "busy after accepted start", busy, 1);
        chk(tx_n == 1'b0, "R2", "leader low after start", tx_n, 0);
        if (disturb) begin
            repeat (1000) @(negedge clk);
            addr = ~a; cmd = ~c; start = 1'b1;          // R7 ignored restart
            @(negedge clk);
            start = 1'b0;
            chk(busy == 1'b1, "R7", "busy held on start while busy", busy, 1);
            repeat (700) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            addr = 16'h5A5A; cmd = 8'h33;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(tx_n == 1'b1, "R1", "tx_n in reset", tx_n, 1);
        chk(busy == 1'b0, "R1", "busy in reset", busy, 0);
        chk(done == 1'b0, "R1", "done in reset", done, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(tx_n == 1'b1, "R1", "idle line after reset", tx_n, 1);

        send_frame(16'h0000, 8'h00, 0, "R6");
        send_frame(16'hFFFF, 8'hFF, 0, "R6");
        send_frame(16'h0001, 8'h80, 0, "R6");
        send_frame(16'hA5C3, 8'h1E, 1, "R7");
        // R9 launch in the done cycle
        while (!done) @(negedge clk);
        send_frame(16'h1234, 8'h56, 0, "R9");
        // R8 counts are checked on every run; R1 mid-frame reset next
        while (!done) @(negedge clk);
        send_frame(16'hBEEF, 8'hC7, 0, "R6");
        repeat (2000) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        exp_lvl.delete(); exp_len.delete(); exp_tag.delete();
        chk(tx_n == 1'b1, "R1", "tx_n after mid-frame reset", tx_n, 1);
        chk(busy == 1'b0, "R1", "busy after mid-frame reset", busy, 0);
        chk(done == 1'b0, "R1", "done after mid-frame reset", done, 0);
        rst_n = 1'b1;
        repeat (50) @(negedge clk);
        chk(tx_n == 1'b1 && busy == 1'b0, "R1", "still idle after reset", tx_n, 1);
        send_frame(16'h8000, 8'h01, 0, "R6");
        while (busy || exp_lvl.size() != 0) @(negedge clk);
        repeat (5) @(negedge clk);
        summary();
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "R6", "watchdog expired", 0, 1);
        summary();
        $finish;
    end

endmodule